// File: doc/BRIEF.md
# Interrupt vector ring producer

This block turns internal interrupt events into 16-byte records and stores them one after another in a circular buffer in memory, so that a host can drain them later. An event carries five fields: a source code, a data word, a ring code, a VM tag and an address-space tag. The block packs these into four 32-bit words and sends them out on a simple memory-write port. It then advances a byte-granular write pointer. The host consumes records and reports its progress by writing a read pointer. While unread records remain, the interrupt output is raised.

The ring size is a power of two. Software programs it as log2 of the size in 32-bit words, and both pointers wrap by masking with the byte size minus one. The block does not stall when it overruns unread data. It keeps writing over the oldest records and raises a sticky overflow flag in bit 31 of the readable write-pointer word. It can also copy that word to a 256-byte-aligned writeback slot after each record. An optional rearm mode produces a fresh interrupt edge when the host moves its read pointer but leaves records behind.

Top module: `intr_ring_producer`

## Requirements
- R1: An accepted event is written as four words in order, at byte address {base,8'h00} + wptr + 4*k for k = 0..3. Word 0 holds the source code in [7:0]. Word 1 holds the source data in [27:0]. Word 2 holds the ring code in [7:0], the VM tag in [15:8] and the address-space tag in [31:16]. Word 3 is zero. All unused bits are zero.
- R2: The write pointer advances by 16 only when the fourth word is accepted, and wraps by masking with ((4 << size) - 1) & ~15.
- R3: The interrupt output is low whenever the read pointer equals the write pointer.
- R4: While ring enable (control bit 0) is 0, ev_ready stays low and no new record is started.
- R5: If a commit makes the write pointer equal to the read pointer, bit 31 of the write-pointer word is set. Writing continues and overwrites the oldest records.
- R6: The overflow flag stays set until a control write with the clear bit (control bit 4, write-one, reads 0) is made.
- R7: With writeback enable (control bit 2) set, each record is followed by one more write of the write-pointer word, including the flag, to address {wbslot,8'h00}.
- R8: With interrupt enable (control bit 1) at 0, the interrupt output is low.
- R9: With rearm (control bit 3) set, a read-pointer write that leaves the ring non-empty drops the interrupt for exactly one cycle. With rearm clear, the interrupt stays high.
- R10: Write-pointer register writes are ignored while the ring is enabled. While it is disabled, such a write loads the masked pointer and clears the overflow flag.
- R11: busy is high from the acceptance of an event until its last word (or its writeback) is accepted. ev_ready is high only when the block is not busy and the ring is enabled.
- R12: While mem_ready is low, mem_valid, mem_addr and mem_data hold their values.
- R13: The register read map is: 0 control (bits [3:0] as above, size in [12:8]), 1 ring base (address bits [39:8]), 2 read pointer, 3 write-pointer word, 4 writeback slot (address bits [39:8]). Reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted this cycle when valid |
| ev_src_id | input | 8 | Source code |
| ev_src_data | input | 28 | Source data |
| ev_ring_id | input | 8 | Ring code |
| ev_vm_id | input | 8 | VM tag |
| ev_pasid | input | 16 | Address-space tag |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory write accepted |
| mem_addr | output | 40 | Byte address of the write |
| mem_data | output | 32 | Write data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt output |
| busy | output | 1 | Record or writeback in progress |

## Verification
Records are sent back to back with memory always ready, and again with memory accepting only every third cycle. The first pattern exposes word order, address stride and pointer-advance timing. The second exposes outputs that fail to hold under back-pressure, and a pointer that moves early. A run of records past the read pointer separates correct flag setting and overwrite from stalling or wrapping wrongly, and a later control clear shows whether the flag is sticky. Read-pointer writes with and without rearm, and event offers while the ring is off, show the interrupt edge behaviour and the gating of acceptance.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int VEC_BYTES = 16;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_BASE  = 3'd1;
    localparam logic [2:0] OFS_RPTR  = 3'd2;
    localparam logic [2:0] OFS_WPTR  = 3'd3;
    localparam logic [2:0] OFS_WBSLT = 3'd4;

    localparam int CB_RING  = 0;
    localparam int CB_IRQ   = 1;
    localparam int CB_WB    = 2;
    localparam int CB_REARM = 3;
    localparam int CB_CLR   = 4;
    localparam int CB_SIZE  = 8;

    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_WB} wr_state_e;

    typedef struct packed {
        logic [7:0]  src_id;
        logic [27:0] src_data;
        logic [7:0]  ring_id;
        logic [7:0]  vm_id;
        logic [15:0] pasid;
    } ivec_t;
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int PTR_W  = 18,
    parameter int SIZE_W = 5,
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              commit,
    output logic              ring_en,
    output logic              wb_en,
    output logic [PTR_W-1:0]  wptr,
    output logic [31:0]       wptr_word,
    output logic [BASE_W-1:0] base,
    output logic [BASE_W-1:0] wb_slot,
    output logic              irq
);
    localparam int PAD_W = 31 - PTR_W;

    typedef struct packed {
        logic              ring_en;
        logic              irq_en;
        logic              wb_en;
        logic              rearm;
        logic [SIZE_W-1:0] size;
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic              ovf;
        logic              drop;
        logic [BASE_W-1:0] base;
        logic [BASE_W-1:0] wb_slot;
    } regs_t;

    regs_t            r_d, r_q;
    logic [PTR_W-1:0] ring_mask;
    logic [PTR_W-1:0] next_wptr;
    logic [PTR_W-1:0] wr_ptr_val;
    logic             clr_hit;

    always_comb begin
        ring_mask  = ((PTR_W'(4) << r_q.size) - PTR_W'(1)) & ~PTR_W'(15);
        next_wptr  = (r_q.wptr + PTR_W'(VEC_BYTES)) & ring_mask;
        wr_ptr_val = reg_wdata[PTR_W-1:0] & ring_mask;
        clr_hit    = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[CB_CLR];
        r_d        = r_q;
        r_d.drop   = 1'b0;
        if (clr_hit) r_d.ovf = 1'b0;
        if (commit) begin
            r_d.wptr = next_wptr;
            if (next_wptr == r_q.rptr) r_d.ovf = 1'b1;
        end
        if (reg_wr) begin
            case (reg_addr)
                OFS_CTRL: begin
                    r_d.ring_en = reg_wdata[CB_RING];
                    r_d.irq_en  = reg_wdata[CB_IRQ];
                    r_d.wb_en   = reg_wdata[CB_WB];
                    r_d.rearm   = reg_wdata[CB_REARM];
                    r_d.size    = reg_wdata[CB_SIZE +: SIZE_W];
                end
                OFS_BASE:  r_d.base    = reg_wdata[BASE_W-1:0];
                OFS_WBSLT: r_d.wb_slot = reg_wdata[BASE_W-1:0];
                OFS_RPTR: begin
                    r_d.rptr = wr_ptr_val;
                    r_d.drop = r_q.rearm && (wr_ptr_val != r_q.wptr);
                end
                OFS_WPTR: begin
                    if (!r_q.ring_en) begin
                        r_d.wptr = wr_ptr_val;
                        r_d.ovf  = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ring_en   = r_q.ring_en;
    assign wb_en     = r_q.wb_en;
    assign wptr      = r_q.wptr;
    assign wptr_word = {r_q.ovf, {PAD_W{1'b0}}, r_q.wptr};
    assign base      = r_q.base;
    assign wb_slot   = r_q.wb_slot;
    assign irq       = r_q.irq_en && (r_q.wptr != r_q.rptr) && !r_q.drop;

    always_comb begin
        case (reg_addr)
            OFS_CTRL:  reg_rdata = 32'({r_q.size, 4'b0000, r_q.rearm, r_q.wb_en,
                                        r_q.irq_en, r_q.ring_en});
            OFS_BASE:  reg_rdata = 32'(r_q.base);
            OFS_RPTR:  reg_rdata = 32'(r_q.rptr);
            OFS_WPTR:  reg_rdata = wptr_word;
            OFS_WBSLT: reg_rdata = 32'(r_q.wb_slot);
            default:   reg_rdata = 32'h0;
        endcase
    end

    // R3: an empty ring never signals
    a_r3_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.wptr == r_q.rptr) |-> !irq);

    // R6: flag survives until cleared or the pointer is reloaded
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovf && !clr_hit && !(reg_wr && reg_addr == OFS_WPTR && !r_q.ring_en))
        |=> r_q.ovf);

    // R9: a rearm gap lasts one cycle
    a_r9_rearm_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && r_q.irq_en && (r_q.wptr != r_q.rptr) && !reg_wr && !commit)
        |=> irq);

    // R8: disabled interrupts stay low
    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.irq_en |-> !irq);
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
    import ivr_pkg::*;
#(
    parameter int PTR_W  = 18,
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ring_en,
    input  logic              wb_en,
    input  logic [ADDR_W-9:0] base,
    input  logic [ADDR_W-9:0] wb_slot,
    input  logic [PTR_W-1:0]  wptr,
    input  logic [31:0]       wptr_word,
    input  logic              ev_valid,
    input  ivec_t             ev,
    output logic              ev_ready,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data,
    output logic              commit,
    output logic              busy
);
    typedef struct packed {
        wr_state_e  st;
        logic [1:0] idx;
        ivec_t      vec;
    } wr_t;

    wr_t w_d, w_q;

    always_comb begin
        w_d    = w_q;
        commit = 1'b0;
        case (w_q.st)
            ST_IDLE: begin
                if (ev_valid && ring_en) begin
                    w_d.vec = ev;
                    w_d.idx = 2'd0;
                    w_d.st  = ST_DATA;
                end
            end
            ST_DATA: begin
                if (mem_ready) begin
                    if (w_q.idx == 2'd3) begin
                        commit = 1'b1;
                        w_d.st = wb_en ? ST_WB : ST_IDLE;
                    end else begin
                        w_d.idx = w_q.idx + 2'd1;
                    end
                end
            end
            ST_WB: if (mem_ready) w_d.st = ST_IDLE;
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '{st: ST_IDLE, default: '0};
        else        w_q <= w_d;
    end

    assign ev_ready  = (w_q.st == ST_IDLE) && ring_en;
    assign mem_valid = (w_q.st != ST_IDLE);
    assign busy      = (w_q.st != ST_IDLE);

    always_comb begin
        if (w_q.st == ST_WB) begin
            mem_addr = {wb_slot, 8'h00};
            mem_data = wptr_word;
        end else begin
            mem_addr = {base, 8'h00} + ADDR_W'(wptr) + ADDR_W'({w_q.idx, 2'b00});
            case (w_q.idx)
                2'd0:    mem_data = {24'h0, w_q.vec.src_id};
                2'd1:    mem_data = {4'h0, w_q.vec.src_data};
                2'd2:    mem_data = {w_q.vec.pasid, w_q.vec.vm_id, w_q.vec.ring_id};
                default: mem_data = 32'h0;
            endcase
        end
    end

    // R12: request is held under back-pressure
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R1: consecutive words step by one word
    a_r1_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == ST_DATA && mem_ready && w_q.idx != 2'd3)
        |=> (mem_addr == $past(mem_addr) + ADDR_W'(4)));

    // R4: no acceptance with the ring off
    a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready |-> ring_en);

    // R11: acceptance and activity are exclusive
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready |-> !busy);
endmodule

// File: rtl/intr_ring_producer.sv
module intr_ring_producer
    import ivr_pkg::*;
#(
    parameter int PTR_W  = 18,
    parameter int SIZE_W = 5,
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [7:0]        ev_src_id,
    input  logic [27:0]       ev_src_data,
    input  logic [7:0]        ev_ring_id,
    input  logic [7:0]        ev_vm_id,
    input  logic [15:0]       ev_pasid,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_data,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              busy
);
    localparam int BASE_W = ADDR_W - 8;

    logic              ring_en, wb_en, commit;
    logic [PTR_W-1:0]  wptr;
    logic [31:0]       wptr_word;
    logic [BASE_W-1:0] base, wb_slot;
    ivec_t             ev;

    assign ev = '{src_id: ev_src_id, src_data: ev_src_data, ring_id: ev_ring_id,
                  vm_id: ev_vm_id, pasid: ev_pasid};

    ivr_regs #(.PTR_W(PTR_W), .SIZE_W(SIZE_W), .BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .commit(commit),
        .ring_en(ring_en), .wb_en(wb_en), .wptr(wptr), .wptr_word(wptr_word),
        .base(base), .wb_slot(wb_slot), .irq(irq)
    );

    ivr_writer #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_writer (
        .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .wb_en(wb_en),
        .base(base), .wb_slot(wb_slot), .wptr(wptr), .wptr_word(wptr_word),
        .ev_valid(ev_valid), .ev(ev), .ev_ready(ev_ready),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .commit(commit), .busy(busy)
    );
endmodule

// File: tb/sim_intr_ring_producer.sv
`timescale 1ns/1ps
module sim_intr_ring_producer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic        ev_ready;
    logic [7:0]  ev_src_id = '0;
    logic [27:0] ev_src_data = '0;
    logic [7:0]  ev_ring_id = '0;
    logic [7:0]  ev_vm_id = '0;
    logic [15:0] ev_pasid = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [39:0] mem_addr;
    logic [31:0] mem_data;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        busy;

    always #10 clk = ~clk;

    intr_ring_producer u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_src_id(ev_src_id), .ev_src_data(ev_src_data), .ev_ring_id(ev_ring_id),
        .ev_vm_id(ev_vm_id), .ev_pasid(ev_pasid), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .busy(busy)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit stall = 0;
    bit done = 0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    typedef struct packed {
        logic [39:0] addr;
        logic [31:0] data;
        logic        last;
        logic        wb;
    } mw_t;
    mw_t wq[$];
    mw_t fr;
    bit  m_ring, m_irqen, m_wb, m_rearm, m_ovf, m_drop, setov, acc;
    int  m_size, m_wptr, m_rptr, old_w, nw;
    logic [31:0] m_base, m_wba, e_rd, e_data;

    function automatic int rmask(int s);
        return ((4 << s) - 1) & ~15 & 32'h3FFFF;
    endfunction

    always @(negedge clk) begin
        chk("R11 busy", busy, wq.size() != 0);
        chk("R11 mem_valid", mem_valid, wq.size() != 0);
        chk("R4 ev_ready", ev_ready, m_ring && wq.size() == 0);
        chk("R3 irq", irq, m_irqen && (m_wptr != m_rptr) && !m_drop);
        if (wq.size() != 0) begin
            fr = wq[0];
            e_data = fr.wb ? ({m_ovf, 31'(m_wptr)}) : fr.data;
            chk(mem_ready ? "R1 addr" : "R12 addr", mem_addr, fr.addr);
            chk(fr.wb ? "R7 data" : "R1 data", mem_data, e_data);
        end
        case (reg_addr)
            3'd0: e_rd = 32'(m_ring) | (32'(m_irqen) << 1) | (32'(m_wb) << 2) |
                         (32'(m_rearm) << 3) | (32'(m_size) << 8);
            3'd1: e_rd = m_base;
            3'd2: e_rd = 32'(m_rptr);
            3'd3: e_rd = {m_ovf, 31'(m_wptr)};
            3'd4: e_rd = m_wba;
            default: e_rd = 32'h0;
        endcase
        chk("R13 rdata", reg_rdata, e_rd);
        if (rst_n) begin
            old_w = m_wptr;
            setov = 0;
            acc   = ev_valid && m_ring && wq.size() == 0;
            if (wq.size() != 0 && mem_ready) begin
                fr = wq.pop_front();
                if (fr.last) begin
                    nw = (m_wptr + 16) & rmask(m_size);
                    if (nw == m_rptr) setov = 1;
                    m_wptr = nw;
                end
            end
            if (reg_wr && reg_addr == 3'd0 && reg_wdata[4]) m_ovf = 0;
            if (setov) m_ovf = 1;
            m_drop = reg_wr && reg_addr == 3'd2 && m_rearm &&
                     ((int'(reg_wdata) & rmask(m_size)) != old_w);
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin
                        m_ring = reg_wdata[0]; m_irqen = reg_wdata[1];
                        m_wb = reg_wdata[2]; m_rearm = reg_wdata[3];
                        m_size = int'(reg_wdata[12:8]);
                    end
                    3'd1: m_base = reg_wdata;
                    3'd2: m_rptr = int'(reg_wdata) & rmask(m_size);
                    3'd3: if (!m_ring) begin
                        m_wptr = int'(reg_wdata) & rmask(m_size);
                        m_ovf = 0;
                    end
                    3'd4: m_wba = reg_wdata;
                    default: ;
                endcase
            end
            if (acc) begin
                for (int k = 0; k < 4; k++) begin
                    fr.addr = {m_base, 8'h00} + 40'(old_w + 4 * k);
                    case (k)
                        0: fr.data = {24'h0, ev_src_id};
                        1: fr.data = {4'h0, ev_src_data};
                        2: fr.data = {ev_pasid, ev_vm_id, ev_ring_id};
                        default: fr.data = 32'h0;
                    endcase
                    fr.last = (k == 3);
                    fr.wb   = 0;
                    wq.push_back(fr);
                end
                if (m_wb) begin
                    fr.addr = {m_wba, 8'h00};
                    fr.data = 32'h0;
                    fr.last = 0;
                    fr.wb   = 1;
                    wq.push_back(fr);
                end
            end
        end
    end

    always @(posedge clk) begin
        #1;
        cyc++;
        mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
        if (cyc > 20000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wreg(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_addr = 3'd3;
    endtask

    task automatic send(logic [7:0] id);
        bit got;
        ev_valid = 1'b1;
        ev_src_id = id;
        ev_src_data = {id[3:0], 24'h5A5A5A} ^ 28'(id);
        ev_ring_id = id + 8'd1;
        ev_vm_id = ~id;
        ev_pasid = {id, 8'hC3};
        do begin
            @(negedge clk); got = ev_ready;
            tick();
        end while (!got);
        ev_valid = 1'b0;
    endtask

    task automatic drain();
        tick();
        while (busy) tick();
        tick();
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] e);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, e);
        tick();
        reg_addr = 3'd3;
    endtask

    initial begin
        m_ring = 0; m_irqen = 0; m_wb = 0; m_rearm = 0; m_ovf = 0; m_drop = 0;
        m_size = 0; m_wptr = 0; m_rptr = 0; m_base = 0; m_wba = 0;
        repeat (3) tick();
        @(negedge clk);
        chk("R13 reset wptr", reg_rdata, 32'h0);
        chk("R3 reset irq", irq, 1'b0);
        rst_n = 1'b1;
        tick();
        wreg(3'd1, 32'h0000_1234);
        wreg(3'd4, 32'h0000_5678);
        wreg(3'd0, 32'h0000_0407);
        // R1 R2: back-to-back with memory always ready
        send(8'h11); send(8'h22); drain();
        stall = 1;
        send(8'h33); drain();
        stall = 0;
        rd_chk("R2 wptr after three", 3'd3, 32'h0000_0030);
        // R9: no rearm, irq stays high
        wreg(3'd2, 32'h10);
        @(negedge clk); chk("R9 no rearm", irq, 1'b1);
        tick();
        wreg(3'd0, 32'h0000_040F);
        wreg(3'd2, 32'h20);
        @(negedge clk); chk("R9 gap", irq, 1'b0);
        tick();
        @(negedge clk); chk("R9 refire", irq, 1'b1);
        tick();
        wreg(3'd2, 32'h30);
        @(negedge clk); chk("R3 empty", irq, 1'b0);
        tick();
        // R5: overrun of unread data
        send(8'h41); send(8'h42); send(8'h43); send(8'h44); drain();
        rd_chk("R5 flag set", 3'd3, 32'h8000_0030);
        send(8'h45); drain();
        rd_chk("R5 overwrite", 3'd3, 32'h8000_0000);
        // R6: clear bit
        wreg(3'd0, 32'h0000_041F);
        rd_chk("R6 cleared", 3'd3, 32'h0000_0000);
        // R10: ignored while enabled
        wreg(3'd3, 32'h20);
        rd_chk("R10 ignored", 3'd3, 32'h0000_0000);
        // R8
        wreg(3'd0, 32'h0000_040D);
        @(negedge clk); chk("R8 masked", irq, 1'b0);
        tick();
        // R4: ring off
        wreg(3'd0, 32'h0000_0400);
        ev_valid = 1'b1;
        repeat (5) begin
            @(negedge clk); chk("R4 refused", ev_ready, 1'b0);
            tick();
        end
        ev_valid = 1'b0;
        wreg(3'd2, 32'h0);
        wreg(3'd3, 32'h10);
        rd_chk("R10 load", 3'd3, 32'h0000_0010);
        wreg(3'd3, 32'h0);
        // R7 off: no writeback, with stalls
        wreg(3'd0, 32'h0000_0403);
        stall = 1;
        send(8'h51); send(8'h52); drain();
        stall = 0;
        rd_chk("R2 wptr no wb", 3'd3, 32'h0000_0020);
        tick();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule